// File: doc/BRIEF.md
# Eight-Bit Timer with Compare-Driven Waveforms

An eight-bit timer/counter that runs entirely on the system clock. A prescaler produces a single-cycle count enable at one of several rates. The counter advances only on that enable, and its upper limit comes either from the full range or from compare register A. Two compare channels watch the count. Each raises a status flag and shapes one waveform output. Four counting disciplines are offered: plain up-counting, clear-on-compare, single-slope PWM and dual-slope PWM. The two PWM disciplines each come in a full-range form and a form whose limit is compare register A.

Software reaches the block through a simple register port. It has a synchronous write strobe with an address and data, and a combinational read selected by a separate address. Status flags are set by hardware events and cleared by writing ones. In the PWM disciplines, values written to the compare registers are staged and take effect only at the turning points of the count. This keeps each period glitch-free.

Top module: `tmr8_pwm`

## Requirements
- R1: After reset every register reads 0x00, the counter holds 0 and both waveform outputs are low.
- R2: The rate field (control bits [5:4]) selects the count enable: 0 stops the counter, 1 enables every clock, 2 every eighth clock, 3 every sixty-fourth clock. The counter changes only on an enable or a software write.
- R3: In every non-dual-slope discipline the count steps up to its limit and then returns to 0. The overflow flag (status bit 0) is set by the enable that moves the count from 255 to 0 (disciplines 0 and 1) or from the limit to 0 (disciplines 2 and 3). It reads 1 in the same cycle as the count reads 0.
- R4: Control bits [2:0] pick the discipline: 0 plain, 1 clear-on-compare, 2 single-slope PWM with limit 255, 3 single-slope PWM with limit from compare A, 4 dual-slope PWM with limit 255, 5 dual-slope PWM with limit from compare A. In disciplines 1, 3 and 5 the limit is compare A; otherwise it is 255. A count that is already above the limit runs on to 255 and wraps to 0.
- R5: The compare B flag (status bit 2) is set on every enable at which the count equals the effective compare B value. The compare A flag (status bit 1) is set the same way, except in disciplines 1, 3 and 5, where it never sets.
- R6: Writing to the status register (offset 4) clears each flag whose data bit is 1 and leaves the others. A flag-setting event in the same cycle wins over the clear.
- R7: A write to the count register (offset 1) loads the count in place of that cycle's step. It also suppresses compare matches on the next enable.
- R8: In disciplines 0 and 1 a match toggles its output. In disciplines 2 and 3 the wrap to 0 drives the output high and a match drives it low; when both happen on one enable, high wins.
- R9: In the PWM disciplines the compare values in use are reloaded from the software registers only at a wrap (single-slope), or at the top or bottom turn (dual-slope). In disciplines 0 and 1 the software values apply immediately.
- R10: In dual-slope disciplines the count rises from 0 to the limit, then falls back to 0. A match while rising drives the output low, and a match while falling drives it high. The overflow flag is set by the enable that turns the count at 0.
- R11: At the enable where the dual-slope count turns at its limit, each output is forced to the level that a rising match would leave. It goes low when its compare value is not above the limit, and high otherwise. A match that was skipped because the count was loaded above the compare value is therefore still reflected at the peak.
- R12: Reads return control at offset 0 (rate in [5:4], discipline in [2:0], other bits 0), count at 1, software compare A at 2, software compare B at 3 and status at 4. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every flop uses its rising edge |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register offset for the write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Register offset for the combinational read |
| rd_data | output | 8 | Read data |
| wave_a | output | 1 | Waveform output of compare channel A |
| wave_b | output | 1 | Waveform output of compare channel B |

## Verification
The interesting coincidence is a hardware flag event and a software clear of the same flag in one cycle. The count is loaded just below 255 at the fastest rate, and the clear write is then swept over four successive offsets so that one of them lands exactly on the wrap. The same sweep also lands the clear on other cycles. A second pairing is a count write followed by an enable that would otherwise match. A cycle-accurate reference model runs alongside the design and predicts the flag and waveform state of every cycle. That model decides the winner by the stated rule: the set wins and the match stays suppressed.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
   // discipline encodings (control bits [2:0])
   localparam logic [2:0] MD_PLAIN   = 3'd0;
   localparam logic [2:0] MD_CLRCMP  = 3'd1;
   localparam logic [2:0] MD_SS_FULL = 3'd2;
   localparam logic [2:0] MD_SS_LIMA = 3'd3;
   localparam logic [2:0] MD_DS_FULL = 3'd4;
   localparam logic [2:0] MD_DS_LIMA = 3'd5;

   // register offsets
   localparam logic [2:0] RG_CTRL = 3'd0;
   localparam logic [2:0] RG_CNT  = 3'd1;
   localparam logic [2:0] RG_CMPA = 3'd2;
   localparam logic [2:0] RG_CMPB = 3'd3;
   localparam logic [2:0] RG_STAT = 3'd4;

   localparam int RATE_LSB = 4;
   localparam int NFLAG    = 3;

   function automatic logic md_pwm(input logic [2:0] m);
      return (m >= MD_SS_FULL) && (m <= MD_DS_LIMA);
   endfunction

   function automatic logic md_dual(input logic [2:0] m);
      return (m == MD_DS_FULL) || (m == MD_DS_LIMA);
   endfunction

   function automatic logic md_single(input logic [2:0] m);
      return (m == MD_SS_FULL) || (m == MD_SS_LIMA);
   endfunction

   function automatic logic md_lim_a(input logic [2:0] m);
      return (m == MD_CLRCMP) || (m == MD_SS_LIMA) || (m == MD_DS_LIMA);
   endfunction
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
   parameter int SEL_W    = 2,
   parameter int STEP_LOG = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int NSEL  = 1 << SEL_W;
   localparam int DIV_W = STEP_LOG * (NSEL - 2);

   generate
      if (SEL_W < 2) begin : g_bad_sel
         $error("tmr_prescaler: SEL_W must be at least 2");
      end
      if (STEP_LOG < 1) begin : g_bad_step
         $error("tmr_prescaler: STEP_LOG must be at least 1");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;
   logic [NSEL-1:0]  taps;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + 1'b1;
   end

   generate
      for (genvar k = 0; k < NSEL; k++) begin : g_tap
         if (k == 0) begin : g_stop
            assign taps[k] = 1'b0;
         end else if (k == 1) begin : g_every
            assign taps[k] = 1'b1;
         end else begin : g_div
            assign taps[k] = &div_q[STEP_LOG*(k-1)-1:0];
         end
      end
   endgenerate

   assign tick = taps[sel];
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dual,
   input  logic         single,
   input  logic [W-1:0] lim,
   output logic [W-1:0] cnt,
   output logic         dir_up,
   output logic         wrap,
   output logic         turn_top,
   output logic         turn_bot,
   output logic         ovf_evt
);
   localparam logic [W-1:0] MAXV = '1;
   localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

   assign wrap     = adv & ~dual & (cnt == lim);
   assign turn_top = adv & dual & dir_up & (cnt >= lim);
   assign turn_bot = adv & dual & ~dir_up & (cnt == '0);

   always_comb begin
      if (dual)        ovf_evt = turn_bot;
      else if (single) ovf_evt = wrap;
      else             ovf_evt = adv & (cnt == MAXV);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         dir_up <= 1'b1;
      end else begin
         if (!dual) dir_up <= 1'b1;
         if (load) begin
            cnt <= load_val;
         end else if (adv) begin
            if (dual) begin
               if (dir_up) begin
                  if (cnt >= lim) begin
                     dir_up <= 1'b0;
                     cnt    <= (cnt == '0) ? '0 : cnt - 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end else begin
                  if (cnt == '0) begin
                     dir_up <= 1'b1;
                     cnt    <= (lim == '0) ? '0 : ONE;
                  end else begin
                     cnt <= cnt - 1'b1;
                  end
               end
            end else begin
               cnt <= wrap ? '0 : cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pwm,
   input  logic         dual,
   input  logic         single,
   input  logic         adv,
   input  logic         blk,
   input  logic [W-1:0] cnt,
   input  logic         dir_up,
   input  logic [W-1:0] lim,
   input  logic [W-1:0] sw,
   input  logic [W-1:0] eff,
   input  logic         wrap,
   input  logic         turn_top,
   input  logic         turn_bot,
   output logic [W-1:0] act,
   output logic         match,
   output logic         wave
);
   logic reload;

   assign match  = adv & ~blk & (cnt == eff);
   assign reload = ~pwm | wrap | turn_top | turn_bot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      act <= '0;
      else if (reload) act <= sw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wave <= 1'b0;
      end else if (dual) begin
         if (turn_top)   wave <= (eff > lim);
         else if (match) wave <= ~dir_up;
      end else if (single) begin
         if (wrap)       wave <= 1'b1;
         else if (match) wave <= 1'b0;
      end else if (match) begin
         wave <= ~wave;
      end
   end
endmodule

// File: rtl/tmr8_pwm.sv
`timescale 1ns/1ps
module tmr8_pwm #(
   parameter int W        = 8,
   parameter int ADDR_W   = 3,
   parameter int SEL_W    = 2,
   parameter int STEP_LOG = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [W-1:0]      wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [W-1:0]      rd_data,
   output logic              wave_a,
   output logic              wave_b
);
   import tmr_pkg::*;

   localparam int            NCH  = 2;
   localparam logic [W-1:0]  MAXV = '1;

   generate
      if (W < RATE_LSB + SEL_W) begin : g_bad_w
         $error("tmr8_pwm: W too narrow for the control fields");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("tmr8_pwm: ADDR_W must be at least 3");
      end
   endgenerate

   logic [2:0]          mode_q;
   logic [SEL_W-1:0]    rate_q;
   logic [NCH-1:0][W-1:0] sw_q;
   logic [NCH-1:0][W-1:0] act;
   logic [NCH-1:0][W-1:0] eff;
   logic [NCH-1:0]      match;
   logic [NCH-1:0]      wave;
   logic [NFLAG-1:0]    flags_q;
   logic                blk_q;

   logic tick, load, adv, wr_ctrl, wr_flags;
   logic pwm, dual, single, lim_a;
   logic [W-1:0] lim, cnt;
   logic dir_up, wrap, turn_top, turn_bot, ovf_evt;
   logic [NFLAG-1:0] flag_set, flag_clr;

   assign wr_ctrl  = wr_en && (wr_addr == ADDR_W'(RG_CTRL));
   assign load     = wr_en && (wr_addr == ADDR_W'(RG_CNT));
   assign wr_flags = wr_en && (wr_addr == ADDR_W'(RG_STAT));
   assign adv      = tick & ~load;

   assign pwm    = md_pwm(mode_q);
   assign dual   = md_dual(mode_q);
   assign single = md_single(mode_q);
   assign lim_a  = md_lim_a(mode_q);
   assign lim    = lim_a ? eff[0] : MAXV;

   tmr_prescaler #(.SEL_W(SEL_W), .STEP_LOG(STEP_LOG)) u_pre (
      .clk(clk), .rst_n(rst_n), .sel(rate_q), .tick(tick)
   );

   tmr_counter #(.W(W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .adv(adv), .load(load), .load_val(wr_data),
      .dual(dual), .single(single), .lim(lim), .cnt(cnt), .dir_up(dir_up),
      .wrap(wrap), .turn_top(turn_top), .turn_bot(turn_bot), .ovf_evt(ovf_evt)
   );

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_ch
         assign eff[g] = pwm ? act[g] : sw_q[g];
         tmr_channel #(.W(W)) u_ch (
            .clk(clk), .rst_n(rst_n), .pwm(pwm), .dual(dual), .single(single),
            .adv(adv), .blk(blk_q), .cnt(cnt), .dir_up(dir_up), .lim(lim),
            .sw(sw_q[g]), .eff(eff[g]), .wrap(wrap), .turn_top(turn_top),
            .turn_bot(turn_bot), .act(act[g]), .match(match[g]), .wave(wave[g])
         );
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sw_q[g] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(RG_CMPA) + ADDR_W'(g)))
               sw_q[g] <= wr_data;
         end
      end
   endgenerate

   assign wave_a = wave[0];
   assign wave_b = wave[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MD_PLAIN;
         rate_q <= '0;
      end else if (wr_ctrl) begin
         mode_q <= wr_data[2:0];
         rate_q <= wr_data[RATE_LSB +: SEL_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    blk_q <= 1'b0;
      else if (load) blk_q <= 1'b1;
      else if (tick) blk_q <= 1'b0;
   end

   assign flag_set = {match[1], match[0] & ~lim_a, ovf_evt};
   assign flag_clr = wr_flags ? wr_data[NFLAG-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~flag_clr) | flag_set;
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADDR_W'(RG_CTRL): begin
            rd_data[2:0]                = mode_q;
            rd_data[RATE_LSB +: SEL_W]  = rate_q;
         end
         ADDR_W'(RG_CNT):  rd_data = cnt;
         ADDR_W'(RG_CMPA): rd_data = sw_q[0];
         ADDR_W'(RG_CMPB): rd_data = sw_q[1];
         ADDR_W'(RG_STAT): rd_data[NFLAG-1:0] = flags_q;
         default:          rd_data = '0;
      endcase
   end
endmodule

// File: rtl/tmr8_pwm_chk.sv
`timescale 1ns/1ps
module tmr8_pwm_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         tick,
   input logic         load,
   input logic [2:0]   mode,
   input logic [W-1:0] cnt,
   input logic         dir_up,
   input logic [W-1:0] lim,
   input logic         wrap,
   input logic         ovf_evt,
   input logic [2:0]   flags,
   input logic         wr_flags,
   input logic [2:0]   clr_bits,
   input logic [1:0]   wave
);
   import tmr_pkg::*;

   // R2
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(cnt));

   // R3
   ovf_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[0]) |-> $past(tick));

   // R5
   cmpa_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[1]) |-> !md_lim_a($past(mode)));

   // R6
   w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_flags && clr_bits[0] && !ovf_evt) |=> !flags[0]);

   // R8
   wrap_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_SS_FULL && wrap) |=> (wave == 2'b11));

   // R10
   rise_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (md_dual(mode) && tick && !load && dir_up && cnt < lim) |=> (cnt == $past(cnt) + 8'd1));
endmodule

bind tmr8_pwm tmr8_pwm_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .mode(mode_q),
   .cnt(cnt), .dir_up(dir_up), .lim(lim), .wrap(wrap), .ovf_evt(ovf_evt),
   .flags(flags_q), .wr_flags(wr_flags), .clr_bits(wr_data[2:0]),
   .wave({wave_b, wave_a})
);

// File: tb/tb_tmr8_pwm.sv
`timescale 1ns/1ps
module tb_tmr8_pwm;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       wave_a, wave_b;

   int errors = 0;
   int checks = 0;
   string cur_tag = "R1";
   bit done = 0;

   always #2.5 clk = ~clk;

   tmr8_pwm dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .wave_a(wave_a), .wave_b(wave_b)
   );

   typedef struct {
      logic [7:0] ctrl, cnt, swa, swb;
      logic [2:0] fl;
      logic       wa, wb;
      string      tag;
   } exp_t;
   exp_t q[$];

   // reference state, derived from the requirement list
   int         m_p;
   logic [2:0] m_mode;
   logic [1:0] m_sel;
   logic [7:0] m_cnt, m_swa, m_swb, m_acta, m_actb;
   logic       m_dir, m_blk, m_wa, m_wb;
   logic [2:0] m_fl;

   function automatic logic f_dual(logic [2:0] m); return m == 4 || m == 5; endfunction
   function automatic logic f_single(logic [2:0] m); return m == 2 || m == 3; endfunction
   function automatic logic f_lima(logic [2:0] m); return m == 1 || m == 3 || m == 5; endfunction

   function automatic logic f_wave(logic w, logic [2:0] m, logic mt, logic wr, logic tt,
                                   logic dir, logic [7:0] e, logic [7:0] lim);
      if (f_dual(m))        return tt ? (e > lim) : (mt ? ~dir : w);
      else if (f_single(m)) return wr ? 1'b1 : (mt ? 1'b0 : w);
      else                  return mt ? ~w : w;
   endfunction

   // driver-side reference: one expected item per clock
   always @(posedge clk) begin
      exp_t it;
      if (!rst_n) begin
         m_p = 0; m_mode = 0; m_sel = 0; m_cnt = 0; m_swa = 0; m_swb = 0;
         m_acta = 0; m_actb = 0; m_dir = 1; m_blk = 0; m_wa = 0; m_wb = 0; m_fl = 0;
      end else begin
         logic tick, load, adv, pwm, dl, sg, wr, tt, tb, ovf, ma, mb;
         logic [7:0] ea, eb, lim;
         logic [2:0] clr;
         tick = (m_sel == 1) || (m_sel == 2 && (m_p % 8) == 7) || (m_sel == 3 && (m_p % 64) == 63);
         load = wr_en && wr_addr == 3'd1;
         adv  = tick && !load;
         pwm  = m_mode >= 2 && m_mode <= 5;
         dl   = f_dual(m_mode);
         sg   = f_single(m_mode);
         ea   = pwm ? m_acta : m_swa;
         eb   = pwm ? m_actb : m_swb;
         lim  = f_lima(m_mode) ? ea : 8'hFF;
         wr   = adv && !dl && m_cnt == lim;
         tt   = adv && dl && m_dir && m_cnt >= lim;
         tb   = adv && dl && !m_dir && m_cnt == 0;
         ovf  = dl ? tb : (sg ? wr : (adv && m_cnt == 8'hFF));
         ma   = adv && !m_blk && m_cnt == ea;
         mb   = adv && !m_blk && m_cnt == eb;
         m_wa = f_wave(m_wa, m_mode, ma, wr, tt, m_dir, ea, lim);
         m_wb = f_wave(m_wb, m_mode, mb, wr, tt, m_dir, eb, lim);
         clr  = (wr_en && wr_addr == 3'd4) ? wr_data[2:0] : 3'b0;
         m_fl = (m_fl & ~clr) | {mb, ma && !f_lima(m_mode), ovf};
         if (!pwm || wr || tt || tb) begin m_acta = m_swa; m_actb = m_swb; end
         if (load) m_cnt = wr_data;
         else if (adv) begin
            if (dl) begin
               if (m_dir) begin
                  if (m_cnt >= lim) begin m_dir = 0; m_cnt = (m_cnt == 0) ? 8'd0 : m_cnt - 8'd1; end
                  else m_cnt = m_cnt + 8'd1;
               end else begin
                  if (m_cnt == 0) begin m_dir = 1; m_cnt = (lim == 0) ? 8'd0 : 8'd1; end
                  else m_cnt = m_cnt - 8'd1;
               end
            end else m_cnt = wr ? 8'd0 : m_cnt + 8'd1;
         end
         if (!dl) m_dir = 1;
         if (load) m_blk = 1; else if (tick) m_blk = 0;
         if (wr_en && wr_addr == 3'd0) begin m_mode = wr_data[2:0]; m_sel = wr_data[5:4]; end
         if (wr_en && wr_addr == 3'd2) m_swa = wr_data;
         if (wr_en && wr_addr == 3'd3) m_swb = wr_data;
         m_p = m_p + 1;
      end
      it.ctrl = {2'b00, m_sel, 1'b0, m_mode};
      it.cnt = m_cnt; it.swa = m_swa; it.swb = m_swb; it.fl = m_fl;
      it.wa = m_wa; it.wb = m_wb; it.tag = cur_tag;
      q.push_back(it);
   end

   // monitor: pops one item per cycle and compares at the falling edge
   always @(negedge clk) begin
      if (q.size() > 0 && !done) begin
         exp_t it;
         logic [7:0] erd;
         it = q.pop_front();
         case (rd_addr)
            3'd0: erd = it.ctrl;
            3'd1: erd = it.cnt;
            3'd2: erd = it.swa;
            3'd3: erd = it.swb;
            3'd4: erd = {5'b0, it.fl};
            default: erd = 8'h00;
         endcase
         checks++;
         if (rd_data !== erd) begin
            errors++;
            $display("FAIL %s rd[%0d] actual=%02h expected=%02h t=%0t", it.tag, rd_addr, rd_data, erd, $time);
         end
         checks++;
         if ({wave_b, wave_a} !== {it.wb, it.wa}) begin
            errors++;
            $display("FAIL %s waves actual=%b expected=%b t=%0t", it.tag, {wave_b, wave_a}, {it.wb, it.wa}, $time);
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      // R1: reset state on every register
      cur_tag = "R1";
      repeat (4) @(posedge clk);
      #1;
      for (int a = 0; a < 5; a++) begin rd_addr = 3'(a); idle(1); end
      rst_n = 1'b1;
      idle(2);

      // R12: register read-back
      cur_tag = "R12";
      wr(3'd2, 8'h5A); wr(3'd3, 8'hC3); wr(3'd0, 8'h00);
      for (int a = 0; a < 8; a++) begin rd_addr = 3'(a); idle(1); end

      // R2: each rate, then stopped
      cur_tag = "R2"; rd_addr = 3'd1;
      wr(3'd0, 8'h10); idle(12);
      wr(3'd0, 8'h20); idle(40);
      wr(3'd0, 8'h30); idle(140);
      wr(3'd0, 8'h00); idle(10);

      // R3: wrap and overflow flag timing
      cur_tag = "R3";
      wr(3'd0, 8'h10); wr(3'd1, 8'd250); idle(8);
      rd_addr = 3'd4; idle(6);

      // R6: clear swept across the wrap cycle
      cur_tag = "R6";
      for (int k = 0; k < 4; k++) begin
         wr(3'd4, 8'h07); wr(3'd1, 8'd252); idle(k);
         wr(3'd4, 8'h01); idle(4);
      end
      wr(3'd4, 8'h02); idle(2);

      // R4: clear-on-compare, including a count above the limit
      cur_tag = "R4";
      wr(3'd2, 8'd20); wr(3'd3, 8'd10); wr(3'd0, 8'h11); wr(3'd1, 8'd0);
      rd_addr = 3'd1; idle(50);
      rd_addr = 3'd4; wr(3'd4, 8'h07); idle(30);
      rd_addr = 3'd1; wr(3'd1, 8'd30); idle(240);

      // R5: compare flags, quiet A flag where A is the limit
      cur_tag = "R5"; rd_addr = 3'd4;
      wr(3'd4, 8'h07); idle(60);
      wr(3'd0, 8'h13); wr(3'd2, 8'd100); wr(3'd3, 8'd50); idle(300);

      // R7: count write suppresses the next match
      cur_tag = "R7";
      wr(3'd0, 8'h10); wr(3'd3, 8'd100); wr(3'd2, 8'd100);
      wr(3'd4, 8'h07); wr(3'd1, 8'd100); idle(4);
      wr(3'd0, 8'h20); wr(3'd4, 8'h07); wr(3'd1, 8'd100); idle(30);

      // R8: toggling in plain mode and single-slope PWM
      cur_tag = "R8"; rd_addr = 3'd1;
      wr(3'd0, 8'h10); wr(3'd2, 8'd64); wr(3'd3, 8'd192); idle(520);
      wr(3'd0, 8'h12); idle(600);

      // R9: staged compare values
      cur_tag = "R9"; rd_addr = 3'd2;
      idle(37); wr(3'd2, 8'd128); idle(120);
      wr(3'd3, 8'd255); idle(400);

      // R10: dual-slope counting
      cur_tag = "R10"; rd_addr = 3'd1;
      wr(3'd2, 8'd50); wr(3'd3, 8'd200); wr(3'd0, 8'h14); wr(3'd1, 8'd0);
      idle(1100);
      rd_addr = 3'd4; wr(3'd4, 8'h07); idle(600);

      // R11: count loaded above compare B on the way up
      cur_tag = "R11"; rd_addr = 3'd1;
      wr(3'd1, 8'd0); idle(20);
      wr(3'd1, 8'd220); idle(700);
      wr(3'd3, 8'd30); wr(3'd2, 8'd90); wr(3'd0, 8'h15); idle(500);

      idle(3);
      finish_run();
   end
endmodule